// File: doc/BRIEF.md
# Bounded-Regime Posit Encoder

This block is the packing stage of a posit arithmetic datapath. It takes a result that an arithmetic unit has already normalised and turns it into an N-bit posit word. The result arrives as a sign, a signed power-of-two scale and the fraction bits that follow the hidden one. Two flags mark the special values zero and not-a-real. The format caps the regime field at six bits and fixes the exponent field at five bits. As a result, the representable scale runs from -192 to +191.

The regime run length is found by XOR-folding the regime value with its own sign. A three-bit select then drives a tiny decoder that picks one of five fixed packing layouts, one per regime size from two to six bits. Each layout is a fixed wiring of regime, exponent and fraction, so the block needs no variable-distance shifter. The block rounds the chosen layout to nearest-even at the cut point, saturates out-of-range scales, and negates the word for negative results. It is purely combinational.

Top module: `bposit_encoder`

## Requirements
- R1: When `nar_i` is 1 the output is a 1 in bit N-1 with all other bits 0, whatever the other inputs are.
- R2: When `zero_i` is 1 and `nar_i` is 0 the output is all zeros.
- R3: For an in-range scale the regime value is k = floor(scale/32), and the regime starts at bit N-2. For k >= 0 the regime is k+1 ones followed by a single 0, and the 0 is omitted when the run already fills six bits (k = 5). For k < 0 the regime is -k zeros followed by a 1, and the 1 is omitted when the run already fills six bits (k = -6).
- R4: The five bits that follow the regime hold scale - 32k, MSB first. The fraction input then fills the remaining low bits, MSB first.
- R5: Fraction bits below the kept width are rounded to nearest, with ties to even. A rounding carry ripples upward through the exponent and regime bits.
- R6: A scale above 191 gives the largest magnitude, 0 followed by N-1 ones.
- R7: A scale below -192 gives the smallest nonzero magnitude (value 1). So does any in-range result that would otherwise pack to zero.
- R8: When `sign_i` is 1, the output is the two's complement of the magnitude pattern the same inputs give with `sign_i` at 0.
- R9: Rounding never carries the largest magnitude over into the sign bit. A kept pattern of all ones stays all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sign_i | input | 1 | Sign of the result, 1 = negative |
| zero_i | input | 1 | Result is exactly zero |
| nar_i | input | 1 | Result is not-a-real (overrides zero) |
| scale_i | input | SW (9) | Signed power-of-two scale of the result |
| frac_i | input | FW (16) | Fraction bits after the hidden one, MSB first |
| posit_o | output | N (16) | Packed posit word |

## Verification
Every result of this block is due in the same cycle as its stimulus, because no register lies between input and output. The bench applies each vector one time unit after a rising edge and samples `posit_o` on the following falling edge. Each check therefore sees a settled output of the current vector and never a leftover from the previous one. The sweep covers every scale from -200 to 199 under both signs and several fraction patterns. These include exact ties, and runs of ones that force a carry into the exponent and regime.

// File: rtl/bposit_enc_pkg.sv
package bposit_enc_pkg;
  // regime field is at most this many bits
  localparam int RS = 6;
  // exponent field width
  localparam int ES = 5;
  // one layout per regime size 2..RS
  localparam int NLAY = RS - 1;
  // signed regime value width (covers -6..5)
  localparam int KW = 4;
  // in-range scale limits
  localparam int SCALE_MAX = (RS - 1) * (1 << ES) + (1 << ES) - 1;
  localparam int SCALE_MIN = -RS * (1 << ES);

  // fold the regime value with its sign: k for k>=0, -k-1 for k<0
  function automatic logic [KW-2:0] fold_regime(input logic [KW-1:0] k);
    logic [KW-1:0] f;
    f = k ^ {KW{k[KW-1]}};
    return f[KW-2:0];
  endfunction

  // round-to-nearest-even decision from kept lsb, guard and sticky
  function automatic logic rne_up(input logic lsb, input logic g, input logic s);
    return g & (s | lsb);
  endfunction
endpackage

// File: rtl/bpe_regime.sv
module bpe_regime
  import bposit_enc_pkg::*;
(
  input  logic [KW-1:0]   k_i,
  output logic [NLAY-1:0] sel_o,
  output logic            neg_o,
  output logic            full_o
);
  logic [KW-2:0] m_w;
  logic [KW-2:0] idx_w;

  assign m_w    = fold_regime(k_i);
  assign neg_o  = k_i[KW-1];
  // run reaches the cap with no terminating bit
  assign full_o = (m_w == (KW-1)'(RS - 1));
  // regime size minus two, clipped at the last layout
  assign idx_w  = (m_w > (KW-1)'(NLAY - 1)) ? (KW-1)'(NLAY - 1) : m_w;

  for (genvar g = 0; g < NLAY; g++) begin : g_dec
    assign sel_o[g] = (idx_w == (KW-1)'(g));
  end
endmodule

// File: rtl/bpe_pack.sv
module bpe_pack
  import bposit_enc_pkg::*;
#(
  parameter int FW = 16,
  localparam int L = RS + ES + FW
) (
  input  logic [NLAY-1:0] sel_i,
  input  logic            neg_i,
  input  logic            full_i,
  input  logic [ES-1:0]   exp_i,
  input  logic [FW-1:0]   frac_i,
  output logic [L-1:0]    long_o
);
  logic [L-1:0] lay [NLAY];

  for (genvar g = 0; g < NLAY; g++) begin : g_lay
    localparam int SZ = g + 2;
    logic last;
    if (g == NLAY - 1) begin : g_cap
      assign last = full_i ? ~neg_i : neg_i;
    end else begin : g_term
      assign last = neg_i;
    end
    if (SZ < RS) begin : g_pad
      assign lay[g] = {{(SZ-1){~neg_i}}, last, exp_i, frac_i, {(RS-SZ){1'b0}}};
    end else begin : g_nopad
      assign lay[g] = {{(SZ-1){~neg_i}}, last, exp_i, frac_i};
    end
  end

  always_comb begin
    long_o = '0;
    for (int g = 0; g < NLAY; g++) begin
      if (sel_i[g]) long_o = long_o | lay[g];
    end
  end
endmodule

// File: rtl/bpe_round.sv
module bpe_round
  import bposit_enc_pkg::*;
#(
  parameter int N  = 16,
  parameter int FW = 16,
  localparam int L  = RS + ES + FW,
  localparam int BW = N - 1
) (
  input  logic [L-1:0]  long_i,
  output logic [BW-1:0] body_o,
  output logic          guard_o,
  output logic          round_o
);
  logic [BW-1:0] keep_w;
  logic          sticky_w;

  assign keep_w   = long_i[L-1 -: BW];
  assign guard_o  = long_i[L-1-BW];
  assign sticky_w = |long_i[L-2-BW:0];
  // never round the all-ones pattern into the sign bit
  assign round_o  = rne_up(keep_w[0], guard_o, sticky_w) & ~(&keep_w);
  assign body_o   = keep_w + {{(BW-1){1'b0}}, round_o};
endmodule

// File: rtl/bposit_encoder.sv
module bposit_encoder
  import bposit_enc_pkg::*;
#(
  parameter int N  = 16,
  parameter int FW = 16,
  parameter int SW = 9,
  localparam int L  = RS + ES + FW,
  localparam int BW = N - 1
) (
  input  logic          sign_i,
  input  logic          zero_i,
  input  logic          nar_i,
  input  logic [SW-1:0] scale_i,
  input  logic [FW-1:0] frac_i,
  output logic [N-1:0]  posit_o
);
  logic [NLAY-1:0] layout_sel;
  logic            reg_neg;
  logic            reg_full;
  logic [L-1:0]    long_w;
  logic [BW-1:0]   body_w;
  logic            guard_w;
  logic            round_up_w;
  logic            sat_hi_w;
  logic            sat_lo_w;
  logic [BW-1:0]   mag_w;
  logic [N-1:0]    packed_w;

  assign sat_hi_w = $signed(scale_i) > SCALE_MAX;
  assign sat_lo_w = $signed(scale_i) < SCALE_MIN;

  bpe_regime u_regime (
    .k_i    (scale_i[ES+KW-1:ES]),
    .sel_o  (layout_sel),
    .neg_o  (reg_neg),
    .full_o (reg_full)
  );

  bpe_pack #(.FW(FW)) u_pack (
    .sel_i  (layout_sel),
    .neg_i  (reg_neg),
    .full_i (reg_full),
    .exp_i  (scale_i[ES-1:0]),
    .frac_i (frac_i),
    .long_o (long_w)
  );

  bpe_round #(.N(N), .FW(FW)) u_round (
    .long_i  (long_w),
    .body_o  (body_w),
    .guard_o (guard_w),
    .round_o (round_up_w)
  );

  always_comb begin
    if (sat_hi_w)
      mag_w = '1;
    else if (sat_lo_w || body_w == '0)
      mag_w = {{(BW-1){1'b0}}, 1'b1};
    else
      mag_w = body_w;
  end

  assign packed_w = {1'b0, mag_w};

  always_comb begin
    if (nar_i)
      posit_o = {1'b1, {BW{1'b0}}};
    else if (zero_i)
      posit_o = '0;
    else if (sign_i)
      posit_o = (~packed_w) + {{(N-1){1'b0}}, 1'b1};
    else
      posit_o = packed_w;
  end
endmodule

// File: rtl/bposit_encoder_chk.sv
module bposit_encoder_chk
  import bposit_enc_pkg::*;
#(
  parameter int N = 16
) (
  input logic            sign_i,
  input logic            zero_i,
  input logic            nar_i,
  input logic [N-1:0]    posit_o,
  input logic [NLAY-1:0] layout_sel,
  input logic            guard_w,
  input logic            round_up_w,
  input logic            sat_hi_w
);
  logic [N-1:0] mag_c;
  assign mag_c = posit_o[N-1] ? (~posit_o + {{(N-1){1'b0}}, 1'b1}) : posit_o;

  always_comb begin
    if (nar_i)
      a_r1_nar_word: assert (posit_o == {1'b1, {(N-1){1'b0}}})
        else $error("R1 NaR word wrong");
    if (zero_i && !nar_i)
      a_r2_zero_word: assert (posit_o == '0)
        else $error("R2 zero word wrong");
    if (!zero_i && !nar_i) begin
      a_r7_never_zero: assert (mag_c != '0 && posit_o != {1'b1, {(N-1){1'b0}}})
        else $error("R7 nonzero input packed to zero or NaR");
      a_r8_sign_bit: assert (posit_o[N-1] == sign_i)
        else $error("R8 sign bit mismatch");
    end
    if (!zero_i && !nar_i && sat_hi_w)
      a_r6_saturate: assert (mag_c == {1'b0, {(N-1){1'b1}}})
        else $error("R6 saturation magnitude wrong");
    a_r3_one_layout: assert ($countones(layout_sel) == 1)
      else $error("R3 layout select not one-hot");
    if (round_up_w)
      a_r5_round_needs_guard: assert (guard_w)
        else $error("R5 round-up without guard bit");
  end
endmodule

bind bposit_encoder bposit_encoder_chk #(.N(N)) u_chk (
  .sign_i     (sign_i),
  .zero_i     (zero_i),
  .nar_i      (nar_i),
  .posit_o    (posit_o),
  .layout_sel (layout_sel),
  .guard_w    (guard_w),
  .round_up_w (round_up_w),
  .sat_hi_w   (sat_hi_w)
);

// File: tb/bposit_encoder_tb.sv
module bposit_encoder_tb;
  localparam int N  = 16;
  localparam int FW = 16;
  localparam int SW = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sign_i = 1'b0;
  logic          zero_i = 1'b1;
  logic          nar_i = 1'b0;
  logic [SW-1:0] scale_i = '0;
  logic [FW-1:0] frac_i = '0;
  logic [N-1:0]  posit_o;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bposit_encoder #(.N(N), .FW(FW), .SW(SW)) u_dut (
    .sign_i (sign_i),
    .zero_i (zero_i),
    .nar_i  (nar_i),
    .scale_i(scale_i),
    .frac_i (frac_i),
    .posit_o(posit_o)
  );

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // arithmetic reference: value of the posit built bit-run by bit-run
  function automatic logic [N-1:0] model(input bit s, input int sc, input logic [FW-1:0] f);
    longint unsigned lv, keep, rest;
    int k, e, rlen, sh;
    longint unsigned rval;
    bit g, st;
    logic [N-1:0] m;
    if (sc > 191) keep = 64'h7FFF;
    else if (sc < -192) keep = 1;
    else begin
      k = (sc >= 0) ? sc / 32 : -((-sc + 31) / 32);
      e = sc - 32 * k;
      if (k >= 0) begin
        rlen = (k + 2 > 6) ? 6 : k + 2;
        rval = (k == 5) ? 63 : (((64'd1 << (k + 1)) - 1) << 1);
      end else begin
        rlen = (1 - k > 6) ? 6 : 1 - k;
        rval = (k == -6) ? 0 : 1;
      end
      lv = (rval << (5 + FW)) | (longint'(e) << FW) | longint'(f);
      sh = rlen + 5 + FW - (N - 1);
      keep = lv >> sh;
      g = bit'((lv >> (sh - 1)) & 1);
      rest = lv & ((64'd1 << (sh - 1)) - 1);
      st = (rest != 0);
      if (g && (st || keep[0]) && keep != 64'h7FFF) keep = keep + 1;
      if (keep == 0) keep = 1;
    end
    m = {1'b0, keep[N-2:0]};
    return s ? N'(-m) : m;
  endfunction

  task automatic apply(input bit s, input bit z, input bit n, input int sc, input logic [FW-1:0] f);
    @(posedge clk);
    #1;
    sign_i = s; zero_i = z; nar_i = n; scale_i = SW'(sc); frac_i = f;
    @(negedge clk);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 200000 && !done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog act=%0d exp=<200000", cycles);
      report();
    end
  end

  initial begin
    logic [FW-1:0] fr [6];
    logic [FW-1:0] lfsr;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 reset state zero", posit_o, '0);

    // R1: NaR dominates zero and everything else
    apply(1, 1, 1, 37, 16'hABCD);
    check("R1 nar over zero", posit_o, 16'h8000);
    apply(0, 0, 1, 300, 16'hFFFF);
    check("R1 nar", posit_o, 16'h8000);
    // R2
    apply(1, 1, 0, -5, 16'h1234);
    check("R2 zero", posit_o, 16'h0000);
    // R3 layouts
    apply(0, 0, 0, 0, 16'h0000);
    check("R3 k=0", posit_o, 16'h4000);
    apply(0, 0, 0, 160, 16'h0000);
    check("R3 k=5 capped", posit_o, 16'h7E00);
    apply(0, 0, 0, -160, 16'h0000);
    check("R3 k=-5", posit_o, 16'h0200);
    // R4 exponent placement
    apply(0, 0, 0, 5, 16'h0000);
    check("R4 exp=5", posit_o, 16'h4500);
    // R5 ties and carry
    apply(0, 0, 0, 0, 16'h0180);
    check("R5 tie to even up", posit_o, 16'h4002);
    apply(0, 0, 0, 0, 16'h0080);
    check("R5 tie to even stay", posit_o, 16'h4000);
    apply(0, 0, 0, 0, 16'hFFFF);
    check("R5 carry into exponent", posit_o, 16'h4100);
    // R6 / R7 / R9
    apply(0, 0, 0, 250, 16'h0000);
    check("R6 saturate high", posit_o, 16'h7FFF);
    apply(0, 0, 0, -250, 16'h0000);
    check("R7 clamp low", posit_o, 16'h0001);
    apply(0, 0, 0, -192, 16'h0000);
    check("R7 packs to zero", posit_o, 16'h0001);
    apply(0, 0, 0, 191, 16'hFFFF);
    check("R9 no wrap", posit_o, 16'h7FFF);
    // R8
    apply(1, 0, 0, 0, 16'h0000);
    check("R8 negate", posit_o, 16'hC000);

    // sweep
    fr[0] = 16'h0000; fr[1] = 16'hFFFF; fr[2] = 16'h8000;
    fr[3] = 16'h0080; fr[4] = 16'h0180; fr[5] = 16'h0000;
    lfsr = 16'hACE1;
    for (int sc = -200; sc < 200; sc++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      fr[5] = lfsr;
      for (int s = 0; s < 2; s++) begin
        for (int fi = 0; fi < 6; fi++) begin
          apply(bit'(s), 0, 0, sc, fr[fi]);
          if (sc > 191) check("R6 sweep", posit_o, model(bit'(s), sc, fr[fi]));
          else if (sc < -192) check("R7 sweep", posit_o, model(bit'(s), sc, fr[fi]));
          else if (s == 1) check("R8 sweep", posit_o, model(1'b1, sc, fr[fi]));
          else check("R3 R4 R5 sweep", posit_o, model(1'b0, sc, fr[fi]));
        end
      end
    end
    done = 1'b1;
    report();
  end
endmodule